// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Refresh and Unlock

The block is a system watchdog on a 16-bit register bus. When enabled, a 32-bit timer advances once every `presc+1` ticks of the selected source, which is either the core clock or an alternate tick input. Software must refresh the timer by writing a two-word key to a dedicated register before the timer reaches the programmed timeout. In windowed mode, a refresh that comes too early is also a fault. Any fault produces a one-cycle `wdog_rst_o` pulse. If the early-warning interrupt is enabled, the pulse is delayed by a fixed number of clocks after the interrupt flag rises.

Configuration registers can only be written during a short period after a separate two-word unlock key, and only while the update-allow bit is still set. Once software clears that bit, it stays clear until the next power-on reset. Writing a wrong word to the unlock register is treated as a fault. A 16-bit counter records how many reset pulses have been issued. The reset pulse returns the timer to zero and leaves the configuration in place.

Top module: `wdg_top`

## Requirements
- R1: After `rst_ni`, the registers read as follows. Control-high (word 0) reads 0x0010: watchdog disabled, update-allow set. Timeout-low (word 3) reads the `RST_TIMEOUT` low half. The reset count (word 10) reads 0. `irq_o` and `wdog_rst_o` are low. Register map, by word address: 0 control-high (bit0 enable, bit1 alternate source, bit2 interrupt enable, bit3 window enable, bit4 update-allow); 1 control-low (bit15 interrupt flag); 2/3 timeout high/low; 4/5 window high/low; 6 refresh; 7 unlock; 8/9 timer high/low (read only); 10 reset count; 11 prescaler.
- R2: With the interrupt disabled, the enable write at edge E is followed by a `wdog_rst_o` pulse exactly one cycle long, asserted after edge E+(presc+1)*timeout+1. The pulse clears the timer.
- R3: The prescaler value is taken from bits 10:8 of word 11. Each value from 0 to 7 stretches the timer period to value+1 source ticks.
- R4: Writing 0xA602 and then 0xB480 to word 6 while the watchdog is enabled clears the timer in the cycle of the second write. A lone 0xB480, or a sequence broken by any other word, leaves the timer counting.
- R5: With window enable set, completing a refresh while the timer is below the 32-bit window value raises `wdog_rst_o` in the next cycle. A refresh at or above the window value clears the timer without a reset.
- R6: With interrupt enable set, a fault sets the control-low bit15 flag and raises `irq_o` in the next cycle. `wdog_rst_o` then follows `IRQ_DELAY` clocks later. Writing 1 to bit15 clears the flag.
- R7: Writing 0xC520 and then 0xD928 to word 7 opens a configuration period of `UNLOCK_WIN` cycles. Writes to words 0, 2, 3, 4, 5 and 11 outside that period have no effect.
- R8: A write to word 7 of any word other than 0xC520, or other than 0xD928 when it is expected, raises `wdog_rst_o` in the next cycle.
- R9: After update-allow (word 0 bit4) is written to 0, configuration writes are ignored even within an unlock period, and the bit cannot be set again.
- R10: Every `wdog_rst_o` pulse increments the reset count, which saturates at 0xFFFF. Writing ones to word 10 clears the matching bits.
- R11: The current 32-bit timer value reads as a high half at word 8 and a low half at word 9.
- R12: With word 0 bit1 set, the timer advances only on cycles where `alt_tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| alt_tick_i | input | 1 | Alternate counting source |
| irq_o | output | 1 | Early-warning interrupt (interrupt flag) |
| wdog_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
The bench builds the block with its default parameters: a 3-bit prescaler, a 16-cycle unlock period and a 256-clock interrupt-to-reset delay. The bench programs very small timeouts of 4 and 6, so it can sweep every prescaler setting against two timeouts and compare each reset latency against the arithmetic figure. The short unlock period lets the bench test the closed-period case within a few cycles. The full 256-clock delay is measured end to end.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 4;

  localparam logic [AW-1:0] A_CTRL_HI = 4'd0;
  localparam logic [AW-1:0] A_CTRL_LO = 4'd1;
  localparam logic [AW-1:0] A_TO_HI   = 4'd2;
  localparam logic [AW-1:0] A_TO_LO   = 4'd3;
  localparam logic [AW-1:0] A_WIN_HI  = 4'd4;
  localparam logic [AW-1:0] A_WIN_LO  = 4'd5;
  localparam logic [AW-1:0] A_REFRESH = 4'd6;
  localparam logic [AW-1:0] A_UNLOCK  = 4'd7;
  localparam logic [AW-1:0] A_TMR_HI  = 4'd8;
  localparam logic [AW-1:0] A_TMR_LO  = 4'd9;
  localparam logic [AW-1:0] A_RSTCNT  = 4'd10;
  localparam logic [AW-1:0] A_PRESC   = 4'd11;

  localparam logic [DW-1:0] KEY_REFRESH_A = 16'hA602;
  localparam logic [DW-1:0] KEY_REFRESH_B = 16'hB480;
  localparam logic [DW-1:0] KEY_UNLOCK_A  = 16'hC520;
  localparam logic [DW-1:0] KEY_UNLOCK_B  = 16'hD928;

  localparam int unsigned PRESC_LSB = 8;
  localparam int unsigned FLAG_BIT  = 15;

  // bit order matches control-high bits 4..0
  typedef struct packed {
    logic allow;
    logic win_en;
    logic irq_en;
    logic alt_src;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned PW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          src_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q == div_i);
  assign tick_o = en_i && !clr_i && src_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || clr_i)  cnt_q <= '0;
    else if (src_i)           cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_keyseq.sv
module wdg_keyseq #(
  parameter int unsigned DW = 16,
  parameter logic [DW-1:0] KEY_A = '0,
  parameter logic [DW-1:0] KEY_B = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          done_o
);
  logic armed_q;

  assign done_o = wr_i && armed_q && (data_i == KEY_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   armed_q <= 1'b0;
    else if (wr_i) armed_q <= !done_o && (data_i == KEY_A);
  end
endmodule

// File: rtl/wdg_fault.sv
module wdg_fault #(
  parameter int unsigned DELAY = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic irq_en_i,
  output logic flag_set_o,
  output logic rst_o
);
  localparam int unsigned DCW = (DELAY > 1) ? $clog2(DELAY) : 1;

  logic           pend_q, rst_q, busy;
  logic [DCW-1:0] dcnt_q;

  assign busy       = pend_q || rst_q;
  assign flag_set_o = trig_i && !busy && irq_en_i;
  assign rst_o      = rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
      dcnt_q <= '0;
    end else begin
      rst_q <= 1'b0;
      if (trig_i && !busy) begin
        if (irq_en_i) begin
          pend_q <= 1'b1;
          dcnt_q <= DCW'(DELAY - 1);
        end else begin
          rst_q <= 1'b1;
        end
      end else if (pend_q) begin
        if (dcnt_q == '0) begin
          pend_q <= 1'b0;
          rst_q  <= 1'b1;
        end else begin
          dcnt_q <= dcnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int unsigned PW          = 3,
  parameter int unsigned UNLOCK_WIN  = 16,
  parameter int unsigned IRQ_DELAY   = 256,
  parameter logic [31:0] RST_TIMEOUT = 32'h0000_1000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          alt_tick_i,
  output logic          irq_o,
  output logic          wdog_rst_o
);
  localparam int unsigned TW  = 2 * DW;
  localparam int unsigned OW  = $clog2(UNLOCK_WIN + 1);

  ctrl_t          ctrl_q;
  logic           flag_q;
  logic [TW-1:0]  toval_q, win_q, timer_q;
  logic [DW-1:0]  rcnt_q;
  logic [PW-1:0]  presc_q;
  logic [OW-1:0]  open_q;

  logic unlock_open, cfg_ok, irq_en_w;
  logic refresh_done, unlock_done, unlock_bad;
  logic win_fault, refresh_clr, timeout, trig;
  logic tick, flag_set, src;

  assign unlock_open = (open_q != '0);
  assign cfg_ok      = unlock_open && ctrl_q.allow;
  assign irq_en_w    = ctrl_q.irq_en;

  wdg_keyseq #(.DW(DW), .KEY_A(KEY_REFRESH_A), .KEY_B(KEY_REFRESH_B)) u_refresh (
    .clk_i, .rst_ni,
    .wr_i   (wr_i && addr_i == A_REFRESH && ctrl_q.en),
    .data_i (wdata_i),
    .done_o (refresh_done)
  );

  wdg_keyseq #(.DW(DW), .KEY_A(KEY_UNLOCK_A), .KEY_B(KEY_UNLOCK_B)) u_unlock (
    .clk_i, .rst_ni,
    .wr_i   (wr_i && addr_i == A_UNLOCK),
    .data_i (wdata_i),
    .done_o (unlock_done)
  );

  assign unlock_bad  = wr_i && addr_i == A_UNLOCK && !unlock_done && wdata_i != KEY_UNLOCK_A;
  assign win_fault   = refresh_done && ctrl_q.win_en && (timer_q < win_q);
  assign refresh_clr = refresh_done && !win_fault;
  assign timeout     = ctrl_q.en && (timer_q >= toval_q);
  assign trig        = timeout || win_fault || unlock_bad;
  assign src         = ctrl_q.alt_src ? alt_tick_i : 1'b1;

  wdg_prescaler #(.PW(PW)) u_presc (
    .clk_i, .rst_ni,
    .en_i   (ctrl_q.en),
    .clr_i  (wdog_rst_o || refresh_clr),
    .src_i  (src),
    .div_i  (presc_q),
    .tick_o (tick)
  );

  wdg_fault #(.DELAY(IRQ_DELAY)) u_fault (
    .clk_i, .rst_ni,
    .trig_i     (trig),
    .irq_en_i   (ctrl_q.irq_en),
    .flag_set_o (flag_set),
    .rst_o      (wdog_rst_o)
  );

  assign irq_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   timer_q <= '0;
    else if (!ctrl_q.en || wdog_rst_o || refresh_clr) timer_q <= '0;
    else if (tick && timer_q != '1)                timer_q <= timer_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          open_q <= '0;
    else if (unlock_done) open_q <= OW'(UNLOCK_WIN);
    else if (unlock_open) open_q <= open_q - 1'b1;
  end

  // configuration registers, gated by unlock period and allow bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= ctrl_t'(5'b10000);
      toval_q <= RST_TIMEOUT;
      win_q   <= '0;
      presc_q <= '0;
    end else if (wr_i && cfg_ok) begin
      case (addr_i)
        A_CTRL_HI: ctrl_q <= ctrl_t'({wdata_i[4] & ctrl_q.allow, wdata_i[3:0]});
        A_TO_HI:   toval_q[TW-1:DW] <= wdata_i;
        A_TO_LO:   toval_q[DW-1:0]  <= wdata_i;
        A_WIN_HI:  win_q[TW-1:DW]   <= wdata_i;
        A_WIN_LO:  win_q[DW-1:0]    <= wdata_i;
        A_PRESC:   presc_q <= wdata_i[PRESC_LSB +: PW];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                              flag_q <= 1'b0;
    else if (flag_set)                                        flag_q <= 1'b1;
    else if (wr_i && addr_i == A_CTRL_LO && wdata_i[FLAG_BIT]) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              rcnt_q <= '0;
    else if (wr_i && addr_i == A_RSTCNT)      rcnt_q <= rcnt_q & ~wdata_i;
    else if (wdog_rst_o && rcnt_q != '1)      rcnt_q <= rcnt_q + 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL_HI: rdata_o = DW'(ctrl_q);
      A_CTRL_LO: rdata_o[FLAG_BIT] = flag_q;
      A_TO_HI:   rdata_o = toval_q[TW-1:DW];
      A_TO_LO:   rdata_o = toval_q[DW-1:0];
      A_WIN_HI:  rdata_o = win_q[TW-1:DW];
      A_WIN_LO:  rdata_o = win_q[DW-1:0];
      A_TMR_HI:  rdata_o = timer_q[TW-1:DW];
      A_TMR_LO:  rdata_o = timer_q[DW-1:0];
      A_RSTCNT:  rdata_o = rcnt_q;
      A_PRESC:   rdata_o[PRESC_LSB +: PW] = presc_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
  import wdg_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic          irq_o,
  input logic          wdog_rst_o,
  input logic          irq_en,
  input logic [31:0]   timer,
  input logic [DW-1:0] rcnt,
  input logic [DW-1:0] toval_lo,
  input logic          unlock_open
);
  assert_rst_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> !wdog_rst_o);

  assert_rst_clears_timer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> timer == 32'd0);

  assert_irq_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en));

  assert_locked_timeout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_TO_LO && !unlock_open) |=> $stable(toval_lo));

  assert_count_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdog_rst_o && !(wr_i && addr_i == A_RSTCNT) && rcnt != 16'hFFFF)
      |=> rcnt == $past(rcnt) + 16'd1);
endmodule

bind wdg_top wdg_checker u_wdg_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .addr_i      (addr_i),
  .irq_o       (irq_o),
  .wdog_rst_o  (wdog_rst_o),
  .irq_en      (irq_en_w),
  .timer       (timer_q),
  .rcnt        (rcnt_q),
  .toval_lo    (toval_q[15:0]),
  .unlock_open (unlock_open)
);

// File: tb/tb_wdg_top.sv
module tb_wdg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        alt_tick = 1'b0;
  logic        irq, wrst;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wdg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .alt_tick_i(alt_tick), .irq_o(irq), .wdog_rst_o(wrst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic unlock();
    wr_reg(4'd7, 16'hC520);
    wr_reg(4'd7, 16'hD928);
  endtask

  task automatic refresh();
    wr_reg(4'd6, 16'hA602);
    wr_reg(4'd6, 16'hB480);
  endtask

  task automatic cfg(input logic [15:0] ctrl, input logic [31:0] to, input logic [31:0] win,
                     input int p);
    unlock();
    wr_reg(4'd0, 16'h0010);
    wr_reg(4'd2, to[31:16]);
    wr_reg(4'd3, to[15:0]);
    wr_reg(4'd4, win[31:16]);
    wr_reg(4'd5, win[15:0]);
    wr_reg(4'd11, 16'(p << 8));
    wr_reg(4'd0, ctrl);
  endtask

  task automatic measure(output int k);
    k = 0;
    while (!wrst && k < 2000) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int k;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    rd_reg(4'd0, d);  chk("R1 ctrl", d, 16'h0010);
    rd_reg(4'd3, d);  chk("R1 timeout lo", d, 16'h1000);
    rd_reg(4'd10, d); chk("R1 count", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst", wrst, 0);

    // R2 R3 latency sweep over every prescaler value
    for (int p = 0; p < 8; p++) begin
      for (int t = 4; t <= 6; t += 2) begin
        cfg(16'h0011, t, 0, p);
        measure(k);
        chk($sformatf("R2 R3 latency p=%0d t=%0d", p, t), k, (p + 1) * t + 1);
        @(negedge clk);
        chk("R2 pulse width", wrst, 0);
      end
    end
    // R10 count and clear
    rd_reg(4'd10, d); chk("R10 count after sweep", d, 16);
    wr_reg(4'd10, 16'h0006);
    rd_reg(4'd10, d); chk("R10 partial clear", d, 16);
    wr_reg(4'd10, 16'hFFFF);
    rd_reg(4'd10, d); chk("R10 full clear", d, 0);

    // R4 R11 refresh
    cfg(16'h0011, 20, 0, 0);
    wait_n(10);
    refresh();
    rd_reg(4'd9, d); chk("R4 refresh clears lo", d, 0);
    rd_reg(4'd8, d); chk("R11 timer hi", d, 0);
    for (int i = 0; i < 3; i++) begin
      wait_n(10);
      refresh();
    end
    rd_reg(4'd10, d); chk("R4 no reset while refreshed", d, 0);
    wait_n(5);
    rd_reg(4'd9, d); chk("R11 timer lo", d, 5);
    wr_reg(4'd6, 16'hB480);
    rd_reg(4'd9, d); chk("R4 lone second key", d, 6);
    wr_reg(4'd6, 16'hA602);
    wr_reg(4'd6, 16'h1234);
    wr_reg(4'd6, 16'hB480);
    rd_reg(4'd9, d); chk("R4 broken sequence", d, 9);

    // R5 window
    cfg(16'h0019, 40, 12, 0);
    wait_n(25);
    refresh();
    chk("R5 late refresh no reset", wrst, 0);
    rd_reg(4'd9, d); chk("R5 late refresh clears", d, 0);
    refresh();
    chk("R5 early refresh resets", wrst, 1);

    // R6 interrupt before reset
    cfg(16'h0015, 4, 0, 0);
    wait_n(4);
    chk("R6 irq not yet", irq, 0);
    wait_n(1);
    chk("R6 irq raised", irq, 1);
    chk("R6 no reset yet", wrst, 0);
    measure(k);
    chk("R6 delayed reset", k + 5, 4 + 1 + 256);
    rd_reg(4'd1, d); chk("R6 flag bit15", d, 16'h8000);
    wr_reg(4'd1, 16'h8000);
    chk("R6 flag cleared", irq, 0);

    // R12 alternate source
    cfg(16'h0013, 3, 0, 0);
    wait_n(30);
    rd_reg(4'd9, d); chk("R12 idle source holds timer", d, 0);
    alt_tick = 1'b1;
    measure(k);
    chk("R12 alternate source latency", k, 4);
    alt_tick = 1'b0;

    // R7 unlock period
    cfg(16'h0010, 32'h100, 0, 0);
    unlock();
    wait_n(20);
    wr_reg(4'd3, 16'h0055);
    rd_reg(4'd3, d); chk("R7 write after period ignored", d, 16'h0100);
    unlock();
    wr_reg(4'd3, 16'h0077);
    rd_reg(4'd3, d); chk("R7 write inside period", d, 16'h0077);

    // R8 wrong unlock word
    wr_reg(4'd7, 16'h1111);
    chk("R8 wrong unlock resets", wrst, 1);
    wr_reg(4'd7, 16'hC520);
    wr_reg(4'd7, 16'h2222);
    chk("R8 wrong second word resets", wrst, 1);

    // R9 allow bit
    unlock();
    wr_reg(4'd0, 16'h0000);
    unlock();
    wr_reg(4'd3, 16'h0099);
    rd_reg(4'd3, d); chk("R9 locked config", d, 16'h0077);
    wr_reg(4'd0, 16'h0010);
    rd_reg(4'd0, d); chk("R9 allow stays clear", d, 16'h0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule